// File: doc/BRIEF.md
# Integer Execute Unit with Set-Compare

This block is the integer arithmetic stage of a 32-bit load/store processor core. Each cycle it takes a first operand, a second operand that is either a register value or a 16-bit immediate, and an operation code. One clock edge later it presents a 32-bit result and an overflow flag. The result register resets asynchronously to zero.

The block widens the immediate itself, and the operation decides how. Arithmetic and compare operations sign-extend it. Bitwise operations zero-extend it. The upper-half load takes the raw 16 bits. Shifts read only the low five bits of the second operand. The six set-compare operations produce the value 0 or 1 and compare as signed numbers.

Overflow is reported only for the two signed add/subtract codes. Multiply, divide, floating point, register-file access and trap dispatch are handled outside the block.

Top module: `int_exec_alu`

## Requirements
- R1: While `rst_n` is low, `result_o` and `ovf_o` are 0.
- R2: The outputs for the inputs present at one rising clock edge appear after that edge and hold until the next edge, a latency of one cycle.
- R3: Codes 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) produce the sum A+B or the difference A-B, modulo 2^32.
- R4: `ovf_o` is 1 only for code 0 or code 2 when the operation overflows in two's complement. It is 0 for ADDU, SUBU and every other code.
- R5: When `use_imm_i` is 1, operand B is the immediate. For codes 0-3 and 11-16, bit 15 of the immediate is copied into bits 31:16, so 0xFFFB acts as -5.
- R6: For codes 4 (AND), 5 (OR) and 6 (XOR) with `use_imm_i` = 1, the immediate is zero-extended.
- R7: Code 7 (upper-half load) returns the immediate in bits 31:16 and zeros in bits 15:0, whatever the value of `use_imm_i` or `rs2_i`.
- R8: Codes 8 (SLL), 9 (SRL) and 10 (SRA) shift A by B[4:0] only. SLL and SRL fill vacated bits with 0, and SRA fills them with A[31].
- R9: Codes 11 (A<B), 12 (A>B), 13 (A<=B), 14 (A>=B), 15 (A==B) and 16 (A!=B) compare as signed numbers and return exactly 1 when true and 0 when false.
- R10: Codes 17 to 31 return a result of 0 with `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| use_imm_i | input | 1 | 1 selects the extended immediate as operand B |
| rs1_i | input | 32 | Operand A |
| rs2_i | input | 32 | Register value for operand B |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The assertions check four rules on every cycle after reset: overflow is raised only for signed add/subtract, set-compare results are 0 or 1, the upper-half load keeps its low half clear, and unused codes return zero. The correct numeric values need the bench's model. These include carries and wraparound, the choice between sign and zero extension, the fill bits of a shift, and which way a signed compare goes at the extremes. The bench drives directed corner cases for these and a long run of random operand mixes.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    localparam int XLEN = 32;
    localparam int IMMW = 16;
    localparam int OPW  = 5;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_LHI  = 5'd7,
        OP_SLL  = 5'd8,  OP_SRL  = 5'd9,  OP_SRA  = 5'd10, OP_SLT  = 5'd11,
        OP_SGT  = 5'd12, OP_SLE  = 5'd13, OP_SGE  = 5'd14, OP_SEQ  = 5'd15,
        OP_SNE  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            ovf;
    } alu_state_s;
endpackage

// File: rtl/alu_imm_widen.sv
module alu_imm_widen #(
    parameter int IMMW = 16,
    parameter int XLEN = 32
) (
    input  logic [IMMW-1:0] imm_i,
    input  logic            zext_i,
    output logic [XLEN-1:0] wide_o
);
    localparam int PADW = XLEN - IMMW;

    logic fill_bit;

    always_comb begin
        fill_bit = zext_i ? 1'b0 : imm_i[IMMW-1];
        wide_o   = {{PADW{fill_bit}}, imm_i};
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            sovf_o
);
    logic [XLEN-1:0] b_eff;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        sum_o  = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
        sovf_o = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  amt_i,
    input  shift_kind_e     kind_i,
    output logic [XLEN-1:0] y_o
);
    always_comb begin
        unique case (kind_i)
            SH_LEFT: y_o = a_i << amt_i;
            SH_RLOG: y_o = a_i >> amt_i;
            SH_RARI: y_o = $unsigned($signed(a_i) >>> amt_i);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_scmp.sv
module alu_scmp #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            lt_o,
    output logic            eq_o
);
    always_comb begin
        lt_o = $signed(a_i) < $signed(b_i);
        eq_o = (a_i == b_i);
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  op_i,
    input  logic            use_imm_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    input  logic [IMMW-1:0] imm_i,
    output logic [XLEN-1:0] result_o,
    output logic            ovf_o
);
    localparam int PADW = XLEN - IMMW;

    alu_op_e         op_s;
    logic            zext_s;
    logic [XLEN-1:0] imm_wide;
    logic [XLEN-1:0] opb;
    logic            sub_s;
    logic [XLEN-1:0] sum_s;
    logic            sovf_s;
    shift_kind_e     sh_kind;
    logic [XLEN-1:0] sh_y;
    logic            lt_s;
    logic            eq_s;
    alu_state_s      st_d;
    alu_state_s      st_q;

    always_comb begin
        op_s    = alu_op_e'(op_i);
        zext_s  = (op_s == OP_AND) || (op_s == OP_OR) || (op_s == OP_XOR);
        opb     = use_imm_i ? imm_wide : rs2_i;
        sub_s   = (op_s == OP_SUB) || (op_s == OP_SUBU);
        sh_kind = (op_s == OP_SRA) ? SH_RARI : ((op_s == OP_SRL) ? SH_RLOG : SH_LEFT);
    end

    alu_imm_widen #(.IMMW(IMMW), .XLEN(XLEN)) u_widen (
        .imm_i  (imm_i),
        .zext_i (zext_s),
        .wide_o (imm_wide)
    );

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a_i    (rs1_i),
        .b_i    (opb),
        .sub_i  (sub_s),
        .sum_o  (sum_s),
        .sovf_o (sovf_s)
    );

    alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .a_i    (rs1_i),
        .amt_i  (opb[SHW-1:0]),
        .kind_i (sh_kind),
        .y_o    (sh_y)
    );

    alu_scmp #(.XLEN(XLEN)) u_cmp (
        .a_i  (rs1_i),
        .b_i  (opb),
        .lt_o (lt_s),
        .eq_o (eq_s)
    );

    always_comb begin
        st_d     = '0;
        st_d.ovf = sovf_s && ((op_s == OP_ADD) || (op_s == OP_SUB));
        case (op_s)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: st_d.res = sum_s;
            OP_AND: st_d.res = rs1_i & opb;
            OP_OR:  st_d.res = rs1_i | opb;
            OP_XOR: st_d.res = rs1_i ^ opb;
            OP_LHI: st_d.res = {imm_i, {PADW{1'b0}}};
            OP_SLL, OP_SRL, OP_SRA: st_d.res = sh_y;
            OP_SLT: st_d.res = XLEN'(lt_s);
            OP_SGT: st_d.res = XLEN'(!lt_s && !eq_s);
            OP_SLE: st_d.res = XLEN'(lt_s || eq_s);
            OP_SGE: st_d.res = XLEN'(!lt_s);
            OP_SEQ: st_d.res = XLEN'(eq_s);
            OP_SNE: st_d.res = XLEN'(!eq_s);
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign ovf_o    = st_q.ovf;
endmodule

// File: rtl/int_exec_alu_chk.sv
module int_exec_alu_chk
    import int_alu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [OPW-1:0]  op_i,
    input logic [IMMW-1:0] imm_i,
    input logic [XLEN-1:0] result_o,
    input logic            ovf_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R4
    only_signed_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) != OP_ADD && $past(op_i) != OP_SUB) |-> !ovf_o);

    // R9
    setcmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= OP_SLT && $past(op_i) <= OP_SNE) |-> (result_o[XLEN-1:1] == '0));

    // R7
    lhi_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_LHI) |->
            (result_o[IMMW-1:0] == '0 && result_o[XLEN-1:XLEN-IMMW] == $past(imm_i)));

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) > OP_SNE) |-> (result_o == '0 && !ovf_o));
endmodule

bind int_exec_alu int_exec_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .imm_i    (imm_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
);

// File: tb/int_exec_alu_tb_top.sv
module int_exec_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] rs1_i = '0;
    logic [31:0] rs2_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    int_exec_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .use_imm_i(use_imm_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i),
        .result_o(result_o), .ovf_o(ovf_o)
    );

    function automatic logic [31:0] opb_f(input logic [4:0] op, input logic ui,
                                          input logic [31:0] r2, input logic [15:0] im);
        if (!ui) return r2;
        if (op >= 5'd4 && op <= 5'd6) return {16'h0000, im};
        return {{16{im[15]}}, im};
    endfunction

    function automatic logic [31:0] exp_res(input logic [4:0] op, input logic ui,
            input logic [31:0] a, input logic [31:0] r2, input logic [15:0] im);
        logic [31:0] b;
        int sh;
        b  = opb_f(op, ui, r2, im);
        sh = int'(b[4:0]);
        case (op)
            5'd0, 5'd1: return a + b;
            5'd2, 5'd3: return a - b;
            5'd4: return a & b;
            5'd5: return a | b;
            5'd6: return a ^ b;
            5'd7: return {im, 16'h0000};
            5'd8: return a << sh;
            5'd9: return a >> sh;
            5'd10: return $unsigned($signed(a) >>> sh);
            5'd11: return {31'd0, $signed(a) <  $signed(b)};
            5'd12: return {31'd0, $signed(a) >  $signed(b)};
            5'd13: return {31'd0, $signed(a) <= $signed(b)};
            5'd14: return {31'd0, $signed(a) >= $signed(b)};
            5'd15: return {31'd0, a == b};
            5'd16: return {31'd0, a != b};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [4:0] op, input logic ui,
            input logic [31:0] a, input logic [31:0] r2, input logic [15:0] im);
        logic [31:0] b;
        logic [31:0] r;
        b = opb_f(op, ui, r2, im);
        if (op == 5'd0) begin
            r = a + b;
            return (a[31] == b[31]) && (r[31] != a[31]);
        end
        if (op == 5'd2) begin
            r = a - b;
            return (a[31] != b[31]) && (r[31] != a[31]);
        end
        return 1'b0;
    endfunction

    function automatic string req_of(input logic [4:0] op);
        if (op <= 5'd3) return "R3";
        if (op <= 5'd6) return "R6";
        if (op == 5'd7) return "R7";
        if (op <= 5'd10) return "R8";
        if (op <= 5'd16) return "R9";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [31:0] got_r, input logic [31:0] exp_r,
                         input logic got_o, input logic exp_o);
        n_chk++;
        if (got_r !== exp_r || got_o !== exp_o) begin
            n_err++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     req, got_r, got_o, exp_r, exp_o);
        end
    endtask

    task automatic apply(input string req, input logic [4:0] op, input logic ui,
                         input logic [31:0] a, input logic [31:0] r2, input logic [15:0] im);
        @(negedge clk);
        op_i = op; use_imm_i = ui; rs1_i = a; rs2_i = r2; imm_i = im;
        @(negedge clk);
        check(req, result_o, exp_res(op, ui, a, r2, im), ovf_o, exp_ovf(op, ui, a, r2, im));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] hold;
        void'($urandom(32'd2024));
        op_i = 5'd0; rs1_i = 32'h7FFF_FFFF; rs2_i = 32'd1;
        repeat (3) @(negedge clk);
        // R1: outputs stay zero in reset even with active inputs
        check("R1", result_o, 32'd0, ovf_o, 1'b0);
        rst_n = 1'b1;

        // R2: the result shows only after the next edge and then holds
        @(negedge clk);
        op_i = 5'd1; use_imm_i = 1'b0; rs1_i = 32'd10; rs2_i = 32'd20;
        @(negedge clk);
        hold = result_o;
        check("R2", result_o, 32'd30, ovf_o, 1'b0);
        op_i = 5'd3;
        #5;
        check("R2", result_o, hold, ovf_o, 1'b0);

        apply("R3", 5'd0, 1'b0, 32'h7FFF_FFFF, 32'd1, 16'h0);       // R4 overflow
        apply("R4", 5'd1, 1'b0, 32'h7FFF_FFFF, 32'd1, 16'h0);
        apply("R4", 5'd2, 1'b0, 32'h8000_0000, 32'd1, 16'h0);
        apply("R4", 5'd3, 1'b0, 32'h0000_0000, 32'd1, 16'h0);
        apply("R4", 5'd0, 1'b0, 32'h8000_0000, 32'h8000_0000, 16'h0);
        apply("R5", 5'd0, 1'b1, 32'd2, 32'hDEAD_BEEF, 16'hFFFB);
        apply("R5", 5'd14, 1'b1, 32'hFFFF_FFFB, 32'd0, 16'hFFFB);
        apply("R5", 5'd11, 1'b1, 32'd0, 32'd0, 16'h8000);
        apply("R6", 5'd4, 1'b1, 32'hFFFF_FFFF, 32'd0, 16'hF0F0);
        apply("R6", 5'd5, 1'b1, 32'h0000_0000, 32'd0, 16'h8001);
        apply("R6", 5'd6, 1'b1, 32'hFFFF_0000, 32'd0, 16'hFFFF);
        apply("R7", 5'd7, 1'b0, 32'h1234_5678, 32'hFFFF_FFFF, 16'hABCD);
        apply("R8", 5'd8, 1'b0, 32'h0000_0001, 32'h0000_0021, 16'h0);
        apply("R8", 5'd9, 1'b1, 32'h8000_0000, 32'd0, 16'hFFFF);
        apply("R8", 5'd10, 1'b0, 32'h8000_0000, 32'd4, 16'h0);
        apply("R8", 5'd10, 1'b0, 32'h4000_0000, 32'd31, 16'h0);
        apply("R9", 5'd11, 1'b0, 32'hFFFF_FFFF, 32'd1, 16'h0);
        apply("R9", 5'd12, 1'b0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
        apply("R9", 5'd13, 1'b0, 32'd5, 32'd5, 16'h0);
        apply("R9", 5'd15, 1'b1, 32'hFFFF_FFFF, 32'd0, 16'hFFFF);
        apply("R9", 5'd16, 1'b0, 32'd7, 32'd7, 16'h0);
        apply("R10", 5'd17, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
        apply("R10", 5'd31, 1'b1, 32'h7FFF_FFFF, 32'd1, 16'h0001);

        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  op;
            logic [31:0] a;
            op = 5'($urandom % 19);
            a  = $urandom;
            if (($urandom % 4) == 0) a = {{31{a[0]}}, a[1]};
            apply(req_of(op), op, 1'($urandom), a, $urandom, 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule